// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the address front end of an I2C target. It watches oversampled SCL and SDA lines, finds Start and Stop conditions, and shifts in the first byte of each transfer. It then decides whether that byte addresses this target. On a hit it copies the byte into a receive buffer, pulls SDA low for the acknowledge bit and raises an interrupt once the acknowledge clock has ended. A host reads the buffer, clears the interrupt and keeps the address register up to date through single-cycle strobes.

Two address widths are supported. With a 7-bit address, the top seven received bits are compared with the address register through a compare mask, and a mask bit of zero makes that bit position a don't-care. A 10-bit address is recognised in two passes. The header byte has the form `11110 A9 A8 0`. After that byte is acknowledged, the target holds SCL low and raises a need-address flag. The host then loads the low address byte, which releases the clock, and the second byte is compared under the mask. After the second byte the clock is held again until the host restores the header byte.

The controller is a state machine with six states. IDLE waits for a Start. SHIFT collects eight bits. ACK drives the acknowledge. HOLD stretches SCL until the address register is written. DONE means this target has been addressed. SKIP means the target is not addressed or the address was refused. A Start moves any state to SHIFT, or to IDLE when the mode is not an addressing mode. A Stop moves any state to IDLE. At the eighth SCL fall, SHIFT moves to ACK when the address is accepted and to SKIP otherwise. At the ninth SCL fall, ACK moves to HOLD in 10-bit mode and to DONE in 7-bit mode. When the address register is written, HOLD moves to SHIFT after the header byte and to DONE after the second byte.

Top module: `i2c_addr_match`

## Requirements
- R1: A Start (SDA falls while SCL is high) or a Stop (SDA rises while SCL is high) restarts the bit count, so an address sent after a partial byte and a new Start is still recognised.
- R2: Address bits are taken on SCL rising edges, most significant bit first. On an accepted address, rx_data equals the whole received byte, including bit 0.
- R3: In modes 4'b0110 and 4'b1001 (7-bit), received bits [7:1] are compared with address register bits [7:1] wherever mask bits [7:1] are one. Received bit 0 (R/W) takes no part in the compare.
- R4: On an accepted address, sda_pull is high from the 8th SCL fall to the 9th SCL fall. On a mismatch, sda_pull stays low.
- R5: An accepted address sets buf_full. A buf_rd strobe clears it.
- R6: A matching address that arrives while buf_full or overflow is set is not acknowledged and does not change rx_data. If buf_full was set, overflow is set. ovf_clr clears overflow.
- R7: irq rises at the 9th SCL fall after an accepted address and is still low during the 9th SCL high phase. irq_clr clears it.
- R8: In mode 4'b0111 (10-bit), the first byte is accepted only if it has the form 11110xx0 and bits [7:1] equal the address register exactly. A header with R/W=1 is not acknowledged.
- R9: After each accepted 10-bit byte, need_addr rises and scl_pull holds SCL low from the 9th SCL fall until an address register write. That write clears need_addr and releases SCL.
- R10: The second 10-bit byte is compared over all eight bits under the mask. On a mismatch there is no acknowledge and no SCL hold.
- R11: The mask resets to 8'hFF. msk_we loads it only while cfg_mode is 4'b1001 and has no effect in any other mode.
- R12: In any mode other than 4'b0110, 4'b0111 and 4'b1001, the block never acknowledges and never holds SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| cfg_mode | input | 4 | Addressing mode select |
| adr_we | input | 1 | Address register write strobe |
| adr_wdata | input | 8 | Address register write data |
| msk_we | input | 1 | Mask register write strobe |
| msk_wdata | input | 8 | Mask register write data |
| buf_rd | input | 1 | Host read of the receive buffer |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| sda_pull | output | 1 | Open-drain SDA pull-down enable |
| scl_pull | output | 1 | Open-drain SCL pull-down enable (clock stretch) |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | An address was refused because the buffer was busy |
| need_addr | output | 1 | Host must rewrite the address register |
| irq | output | 1 | Interrupt flag |

## Verification
Both 7-bit sweeps cover all 128 addresses with alternating R/W. One runs with the reset mask and one with a partial mask. A block that compared bit 0, or that ignored or inverted the mask, would give a wrong acknowledge for some address. The overflow sequence checks three things: a second match sent while the buffer is unread, a read that leaves overflow set, and a clear that restores acknowledges. A design that overwrote the buffer or cleared overflow on a read would fail it. The 10-bit runs cover the clock hold across a long host delay, a header with R/W=1, a wrong A9:A8, a wrong or masked second byte, a Start after a partial byte and a mask write made in the wrong mode. Early release, a wrong hold or a leftover bit count would each show up there.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_ACK,
        S_HOLD,
        S_DONE,
        S_SKIP
    } am_state_e;

    localparam logic [3:0] MODE_7B     = 4'b0110;
    localparam logic [3:0] MODE_10B    = 4'b0111;
    localparam logic [3:0] MODE_7B_MSK = 4'b1001;
    localparam logic [4:0] TEN_HDR     = 5'b11110;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] pipe;
        logic              prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
                prev <= 1'b1;
            end else begin
                pipe <= {pipe[STAGES-2:0], d[g]};
                prev <= pipe[LAST];
            end
        end
        assign q[g]    = pipe[LAST];
        assign rise[g] = pipe[LAST] & ~prev;
        assign fall[g] = ~pipe[LAST] & prev;
    end
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         smp,
    input  logic         din,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            data <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && smp && cnt != CNT_MAX) begin
            cnt  <= cnt + 1'b1;
            data <= {data[W-2:0], din};
        end
    end

    assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] rx,
    input  logic [W-1:0] adr,
    input  logic [W-1:0] msk,
    input  logic         ten,
    input  logic         second,
    output logic         hit
);
    logic [W-1:0] diff;
    logic         hit7, hit_hdr, hit_low;

    assign diff    = rx ^ adr;
    assign hit7    = ((diff[W-1:1] & msk[W-1:1]) == '0);
    assign hit_hdr = (rx[W-1:W-5] == TEN_HDR) && !rx[0] && (diff[W-1:1] == '0);
    assign hit_low = ((diff & msk) == '0);

    always_comb begin
        if (!ten)        hit = hit7;
        else if (second) hit = hit_low;
        else             hit = hit_hdr;
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    input  logic [3:0]   cfg_mode,
    input  logic         adr_we,
    input  logic [W-1:0] adr_wdata,
    input  logic         msk_we,
    input  logic [W-1:0] msk_wdata,
    input  logic         buf_rd,
    input  logic         irq_clr,
    input  logic         ovf_clr,
    output logic         sda_pull,
    output logic         scl_pull,
    output logic [W-1:0] rx_data,
    output logic         buf_full,
    output logic         overflow,
    output logic         need_addr,
    output logic         irq
);
    localparam int L_SCL = 1;
    localparam int L_SDA = 0;

    am_state_e    state, nxt;
    logic [1:0]   bq, brise, bfall;
    logic         scl_fall, start_det, stop_det;
    logic [W-1:0] adr_reg, msk_reg, sh_data;
    logic         sh_full, sh_clr, hit, second;
    logic         mode_ok, ten, at_decide, accept, refuse;

    i2c_am_sync #(.LANES(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_i, sda_i}),
        .q    (bq),
        .rise (brise),
        .fall (bfall)
    );

    assign scl_fall  = bfall[L_SCL];
    assign start_det = bfall[L_SDA] & bq[L_SCL];
    assign stop_det  = brise[L_SDA] & bq[L_SCL];

    assign mode_ok = (cfg_mode == MODE_7B) || (cfg_mode == MODE_10B) ||
                     (cfg_mode == MODE_7B_MSK);
    assign ten     = (cfg_mode == MODE_10B);

    assign sh_clr = start_det | stop_det | (state == S_HOLD && adr_we);

    i2c_am_shift #(.W(W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sh_clr),
        .en   (state == S_SHIFT),
        .smp  (brise[L_SCL]),
        .din  (bq[L_SDA]),
        .data (sh_data),
        .full (sh_full)
    );

    i2c_am_cmp #(.W(W)) u_cmp (
        .rx    (sh_data),
        .adr   (adr_reg),
        .msk   (msk_reg),
        .ten   (ten),
        .second(second),
        .hit   (hit)
    );

    assign at_decide = (state == S_SHIFT) && scl_fall && sh_full;
    assign accept    = at_decide && hit && !buf_full && !overflow;
    assign refuse    = at_decide && hit && (buf_full || overflow);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = mode_ok ? S_SHIFT : S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_SHIFT: if (at_decide) nxt = accept ? S_ACK : S_SKIP;
                S_ACK:   if (scl_fall)  nxt = ten ? S_HOLD : S_DONE;
                S_HOLD:  if (adr_we)    nxt = second ? S_DONE : S_SHIFT;
                S_DONE:  nxt = S_DONE;
                S_SKIP:  nxt = S_SKIP;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        scl_pull = 1'b0;
        unique case (state)
            S_ACK:   sda_pull = 1'b1;
            S_HOLD:  scl_pull = 1'b1;
            default: ;
        endcase
    end

    // host registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_reg   <= '0;
            msk_reg   <= '1;
            rx_data   <= '0;
            buf_full  <= 1'b0;
            overflow  <= 1'b0;
            need_addr <= 1'b0;
            irq       <= 1'b0;
            second    <= 1'b0;
        end else begin
            if (adr_we) adr_reg <= adr_wdata;
            if (msk_we && cfg_mode == MODE_7B_MSK) msk_reg <= msk_wdata;

            if (accept) begin
                rx_data  <= sh_data;
                buf_full <= 1'b1;
            end else if (buf_rd) begin
                buf_full <= 1'b0;
            end

            if (refuse && buf_full) overflow <= 1'b1;
            else if (ovf_clr)       overflow <= 1'b0;

            if (state == S_ACK && scl_fall) irq <= 1'b1;
            else if (irq_clr)              irq <= 1'b0;

            if (state == S_ACK && scl_fall && ten) need_addr <= 1'b1;
            else if (adr_we)                       need_addr <= 1'b0;

            if (start_det)                      second <= 1'b0;
            else if (state == S_HOLD && adr_we) second <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull,
    input logic scl_pull,
    input logic buf_full,
    input logic buf_rd,
    input logic overflow,
    input logic need_addr,
    input logic adr_we,
    input logic irq
);
    assert_ack_with_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> buf_full);

    assert_hold_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> need_addr);

    assert_no_dual_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_pull && scl_pull));

    assert_upd_cleared_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(need_addr) |-> $past(adr_we));

    assert_refuse_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !sda_pull);

    assert_irq_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sda_pull));

    assert_full_cleared_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> $past(buf_rd));
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_pull (sda_pull),
    .scl_pull (scl_pull),
    .buf_full (buf_full),
    .buf_rd   (buf_rd),
    .overflow (overflow),
    .need_addr(need_addr),
    .adr_we   (adr_we),
    .irq      (irq)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
    localparam int H = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [3:0] cfg_mode = 4'b0110;
    logic adr_we = 0, msk_we = 0, buf_rd = 0, irq_clr = 0, ovf_clr = 0;
    logic [7:0] adr_wdata = 0, msk_wdata = 0;
    logic sda_pull, scl_pull, buf_full, overflow, need_addr, irq;
    logic [7:0] rx_data;
    logic scl_bus, sda_bus;
    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign scl_bus = m_scl & ~scl_pull;
    assign sda_bus = m_sda & ~sda_pull;

    i2c_addr_match uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .cfg_mode(cfg_mode), .adr_we(adr_we), .adr_wdata(adr_wdata),
        .msk_we(msk_we), .msk_wdata(msk_wdata), .buf_rd(buf_rd),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .sda_pull(sda_pull),
        .scl_pull(scl_pull), .rx_data(rx_data), .buf_full(buf_full),
        .overflow(overflow), .need_addr(need_addr), .irq(irq)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wclk(H/2);
        m_scl = 1'b1;
        while (!scl_bus) wclk(1);
        wclk(H);
        m_scl = 1'b0; wclk(H/2);
    endtask

    task automatic start_c;
        m_sda = 1'b1; wclk(H/2);
        m_scl = 1'b1; wclk(H);
        m_sda = 1'b0; wclk(H);
        m_scl = 1'b0; wclk(H/2);
    endtask

    task automatic stop_c;
        m_sda = 1'b0; wclk(H/2);
        m_scl = 1'b1; wclk(H);
        m_sda = 1'b1; wclk(H);
    endtask

    // sends a byte; early = pull seen in 9th low phase, ack = pull in 9th high phase
    task automatic send_byte(input logic [7:0] b, output logic early,
                             output logic ack, output logic irq_mid);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda = 1'b1; wclk(H/2);
        early = sda_pull;
        m_scl = 1'b1;
        while (!scl_bus) wclk(1);
        wclk(H/2);
        ack = sda_pull; irq_mid = irq;
        wclk(H/2);
        m_scl = 1'b0; wclk(H/2);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: buf_rd = 1; 1: irq_clr = 1; 2: ovf_clr = 1; 3: adr_we = 1; default: msk_we = 1;
        endcase
        @(negedge clk);
        buf_rd = 0; irq_clr = 0; ovf_clr = 0; adr_we = 0; msk_we = 0;
    endtask

    task automatic host_clear;
        strobe(0); strobe(1);
    endtask

    task automatic set_adr(input logic [7:0] v);
        adr_wdata = v; strobe(3);
    endtask

    task automatic set_msk(input logic [7:0] v);
        msk_wdata = v; strobe(4);
    endtask

    // one 7-bit transaction, checked against a computed expectation
    task automatic one7(input logic [7:0] b, input logic exp, input string req);
        logic e, a, im;
        start_c;
        send_byte(b, e, a, im);
        wclk(2);
        stop_c;
        chk(a == exp, req, a, exp);
        chk(e == exp, "R4 ack from 8th fall", e, exp);
        if (exp) begin
            chk(rx_data == b, "R2 rx_data", rx_data, b);
            chk(buf_full == 1'b1, "R5 buf_full set", buf_full, 1);
            chk(im == 1'b0, "R7 irq low in 9th high", im, 0);
            chk(irq == 1'b1, "R7 irq after 9th fall", irq, 1);
            host_clear;
            chk(buf_full == 1'b0, "R5 buf_rd clears", buf_full, 0);
        end else begin
            chk(buf_full == 1'b0 && irq == 1'b0, "R4 no load on miss", {buf_full, irq}, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic e, a, im;
        logic [6:0] own;
        own = 7'h2D;
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        chk({sda_pull, scl_pull, buf_full, overflow, need_addr, irq} == 6'b0,
            "R11 reset outputs", {sda_pull, scl_pull, buf_full, overflow, need_addr, irq}, 0);
        chk(rx_data == 8'h00, "R2 reset rx_data", rx_data, 0);

        // R3/R11: full sweep, reset mask, R/W alternating
        cfg_mode = 4'b0110;
        set_adr({own, 1'b0});
        for (int k = 0; k < 128; k++)
            one7({7'(k), 1'(k)}, 7'(k) == own, "R3 exact sweep");

        // R11: mask write in wrong mode has no effect
        set_msk(8'h00);
        one7({own ^ 7'h01, 1'b0}, 1'b0, "R11 mask write ignored");

        // R3: masked sweep, mask compares bits [7:4] only
        cfg_mode = 4'b1001;
        set_msk(8'hF0);
        for (int k = 0; k < 128; k++)
            one7({7'(k), 1'(~k)}, ((({7'(k), 1'b0} ^ {own, 1'b0}) & 8'hF0) == 0),
                 "R3 masked sweep");
        set_msk(8'hFF);
        cfg_mode = 4'b0110;

        // R12: unsupported mode
        cfg_mode = 4'b0000;
        one7({own, 1'b0}, 1'b0, "R12 idle mode");
        cfg_mode = 4'b0110;

        // R1: partial byte then repeated start, and partial byte then stop
        start_c; bit_out(1); bit_out(0); bit_out(1);
        start_c;
        send_byte({own, 1'b0}, e, a, im);
        wclk(2); stop_c;
        chk(a == 1'b1, "R1 restart after partial byte", a, 1);
        host_clear;
        start_c; bit_out(0); bit_out(1); stop_c;
        one7({own, 1'b1}, 1'b1, "R1 stop clears count");

        // R6: overflow sequence
        one7({own, 1'b0}, 1'b1, "R6 first match");
        start_c; send_byte({own, 1'b0}, e, a, im); wclk(2); stop_c;
        chk(buf_full == 1'b1, "R6 buf stays full", buf_full, 1);
        start_c; send_byte({own, 1'b1}, e, a, im); wclk(2); stop_c;
        chk(a == 1'b0, "R6 no ack while full", a, 0);
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        chk(rx_data == {own, 1'b0}, "R6 rx_data kept", rx_data, {own, 1'b0});
        host_clear;
        start_c; send_byte({own, 1'b1}, e, a, im); wclk(2); stop_c;
        chk(a == 1'b0, "R6 no ack while overflow", a, 0);
        strobe(2);
        chk(overflow == 1'b0, "R6 ovf_clr", overflow, 0);
        one7({own, 1'b1}, 1'b1, "R6 ack after clear");

        // R8/R9/R10: ten-bit flow, A9:A8 = 01, low = 3C
        cfg_mode = 4'b0111;
        set_adr(8'hF2);
        start_c; send_byte(8'hF2, e, a, im); wclk(4);
        chk(a == 1'b1, "R8 header ack", a, 1);
        chk(need_addr == 1'b1 && scl_pull == 1'b1, "R9 hold after header",
            {need_addr, scl_pull}, 3);
        chk(rx_data == 8'hF2 && irq == 1'b1, "R9 header flags", rx_data, 8'hF2);
        wclk(60);
        chk(scl_bus == 1'b0, "R9 clock still held", scl_bus, 0);
        host_clear;
        set_adr(8'h3C);
        chk(need_addr == 1'b0 && scl_pull == 1'b0, "R9 write releases",
            {need_addr, scl_pull}, 0);
        send_byte(8'h3C, e, a, im); wclk(4);
        chk(a == 1'b1, "R10 low byte ack", a, 1);
        chk(need_addr == 1'b1 && scl_pull == 1'b1 && rx_data == 8'h3C,
            "R9 hold after low byte", rx_data, 8'h3C);
        host_clear;
        set_adr(8'hF2);
        chk(scl_pull == 1'b0, "R9 release after restore", scl_pull, 0);
        stop_c;

        start_c; send_byte(8'hF3, e, a, im); wclk(4); stop_c;
        chk(a == 1'b0 && scl_pull == 1'b0, "R8 read header refused", a, 0);
        start_c; send_byte(8'hF6, e, a, im); wclk(4); stop_c;
        chk(a == 1'b0, "R8 wrong A9:A8", a, 0);

        start_c; send_byte(8'hF2, e, a, im); wclk(4);
        host_clear; set_adr(8'h3C);
        send_byte(8'h3D, e, a, im); wclk(4);
        chk(a == 1'b0, "R10 wrong low byte", a, 0);
        chk(scl_pull == 1'b0 && need_addr == 1'b0, "R10 no hold on miss",
            {scl_pull, need_addr}, 0);
        stop_c;
        set_adr(8'hF2);

        // R10: mask applied to low byte
        cfg_mode = 4'b1001; set_msk(8'h0F); cfg_mode = 4'b0111;
        start_c; send_byte(8'hF2, e, a, im); wclk(4);
        host_clear; set_adr(8'h3C);
        send_byte(8'hAC, e, a, im); wclk(4);
        chk(a == 1'b1, "R10 masked low byte", a, 1);
        host_clear; set_adr(8'hF2);
        stop_c;
        chk(scl_pull == 1'b0, "R9 final release", scl_pull, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule